// File: doc/BRIEF.md
# Banked GPIO Data Register File

This block holds the data-path registers of a general-purpose I/O controller organised in banks of 32 pins. Every bank owns a direction register, an output value register, a pair of atomic write-one-to-set and write-one-to-clear ports onto that output value, and a read-only view of the pin levels after a two-stage synchronizer. Software reaches these registers through a simple word-wide read/write port that uses byte addresses.

The banks sit in equal address windows of 0x28 bytes placed after a 0x10-byte global header. Each window also reserves room for the edge-trigger and interrupt-status words of a separate interrupt block. Those slots read back zero here, and writes to them are dropped. The pins leave the block as three flat vectors: driven value, output enable, and sampled input. Pin `b*32+i` belongs to bit `i` of bank `b`.

Top module: `gpio_banked_regfile`

## Requirements
- R1: After a synchronous reset every direction bit is 1 (all pins inputs, so `pin_oe` is all zero), every output value bit is 0, and `bus_rdata` is 0.
- R2: Bank `b` occupies byte addresses `0x10 + 0x28*b` up to `0x10 + 0x28*b + 0x27`. Its word offsets are: direction at +0x00, output value at +0x04, set port at +0x08, clear port at +0x0C and input level at +0x10. Bit `i` of bank `b` maps to pin `32*b + i` on `pin_out`, `pin_oe` and `pin_in`.
- R3: A direction bit of 1 makes its pin an input (`pin_oe` bit 0). A direction bit of 0 enables the driver (`pin_oe` bit 1). `pin_out` always carries the output value register.
- R4: A write to the set port ORs the written mask into the output value register at the write's clock edge. Bits where the mask is 0 keep their value.
- R5: A write to the clear port clears the masked output value bits at the write's clock edge. Bits where the mask is 0 keep their value.
- R6: A write to the output value word replaces all 32 bits. Reads of the output value word, the set port and the clear port all return the current output value register.
- R7: A read of the input level word returns `pin_in` through two flip-flops per pin, for output pins as well as input pins. After a change on `pin_in` just before edge E1, reads captured at E1 and E2 return the old level, and a read captured at E3 returns the new one.
- R8: `bus_rdata` is registered. It loads the addressed word at the edge where `bus_rd` is high and holds its value while `bus_rd` is low.
- R9: The header (0x00 to 0x0F), the reserved slots of each window (+0x14 to +0x24) and every address past the last window read as 0. A write there changes no register.
- R10: Writes to the input level word are ignored.
- R11: A write that lands in one bank leaves every other bank's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one word |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the edge |
| bus_addr | input | ADDR_W (8) | Byte address; the two low bits are ignored |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_BANKS*32 (160) | Pin levels, asynchronous to `clk` |
| pin_out | output | NUM_BANKS*32 (160) | Output value per pin |
| pin_oe | output | NUM_BANKS*32 (160) | Output enable per pin (1 = drive) |

## Verification
The properties assume that `bus_wr`, `bus_addr` and `bus_wdata` hold known values at every edge after reset, and that only one word is written per cycle. They check only the first bank's fixed window, which relies on a read never being relied on to change state. The stimulus changes all bus and pin inputs on the falling clock edge, never raises `bus_wr` and `bus_rd` together, and changes `pin_in` only when the bench has counted the synchronizer latency before sampling.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int DATA_W     = 32;
    localparam int WORD_BYTES = 4;

    // Register selected inside a bank window
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_OUT  = 3'd2,
        SEL_SET  = 3'd3,
        SEL_CLR  = 3'd4,
        SEL_IN   = 3'd5
    } reg_sel_e;

    // State held by one bank
    typedef struct packed {
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] outv;
    } bank_state_t;

    // Word index inside a window -> register; reserved interrupt words map to none
    function automatic reg_sel_e word_to_sel(input logic [3:0] word);
        reg_sel_e s;
        case (word)
            4'd0:    s = SEL_DIR;
            4'd1:    s = SEL_OUT;
            4'd2:    s = SEL_SET;
            4'd3:    s = SEL_CLR;
            4'd4:    s = SEL_IN;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS    = 5,
    parameter int ADDR_W       = 8,
    parameter int HDR_BYTES    = 16,
    parameter int STRIDE_BYTES = 40
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output reg_sel_e             sel
);

    localparam int OFF_W = 8;

    logic [NUM_BANKS-1:0] hit_v;
    logic [3:0]           word_v [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
        localparam int BASE = HDR_BYTES + b * STRIDE_BYTES;
        int unsigned a_u;
        logic [OFF_W-1:0] off;
        always_comb begin
            a_u      = 32'(addr);
            hit_v[b] = (a_u >= BASE) && (a_u < BASE + STRIDE_BYTES);
            off      = OFF_W'(a_u - BASE);
            word_v[b] = off[5:2];
        end
    end

    always_comb begin
        sel = SEL_NONE;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_v[b]) sel = word_to_sel(word_v[b]);
        end
    end

    assign bank_hit = hit_v;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pins_async,
    output logic [DATA_W-1:0] drv_value,
    output logic [DATA_W-1:0] drv_enable,
    output logic [DATA_W-1:0] rd_word
);

    bank_state_t       st;
    logic [DATA_W-1:0] sync_a;
    logic [DATA_W-1:0] sync_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.dir  <= '1;
            st.outv <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR: st.dir  <= wdata;
                SEL_OUT: st.outv <= wdata;
                SEL_SET: st.outv <= st.outv | wdata;
                SEL_CLR: st.outv <= st.outv & ~wdata;
                default: ;
            endcase
        end
    end

    // two-stage synchronizer on every pin
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= '0;
            sync_b <= '0;
        end else begin
            sync_a <= pins_async;
            sync_b <= sync_a;
        end
    end

    always_comb begin
        case (sel)
            SEL_DIR:                   rd_word = st.dir;
            SEL_OUT, SEL_SET, SEL_CLR: rd_word = st.outv;
            SEL_IN:                    rd_word = sync_b;
            default:                   rd_word = '0;
        endcase
    end

    assign drv_value  = st.outv;
    assign drv_enable = ~st.dir;

endmodule

// File: rtl/gpio_banked_regfile.sv
module gpio_banked_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS    = 5,
    parameter int ADDR_W       = 8,
    parameter int HDR_BYTES    = 16,
    parameter int STRIDE_BYTES = 40,
    localparam int NPINS       = NUM_BANKS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);

    logic [NUM_BANKS-1:0] bank_hit;
    reg_sel_e             sel;
    logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
    logic [DATA_W-1:0]    rd_mux;

    gpio_addr_decode #(
        .NUM_BANKS   (NUM_BANKS),
        .ADDR_W      (ADDR_W),
        .HDR_BYTES   (HDR_BYTES),
        .STRIDE_BYTES(STRIDE_BYTES)
    ) u_dec (
        .addr    (bus_addr),
        .bank_hit(bank_hit),
        .sel     (sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (bus_wr & bank_hit[b]),
            .sel       (sel),
            .wdata     (bus_wdata),
            .pins_async(pin_in [b*DATA_W +: DATA_W]),
            .drv_value (pin_out[b*DATA_W +: DATA_W]),
            .drv_enable(pin_oe [b*DATA_W +: DATA_W]),
            .rd_word   (bank_rd[b])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) rd_mux = rd_mux | bank_rd[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_banked_regfile_chk.sv
module gpio_banked_regfile_chk #(
    parameter int NUM_BANKS    = 5,
    parameter int ADDR_W       = 8,
    parameter int HDR_BYTES    = 16,
    parameter int STRIDE_BYTES = 40,
    localparam int NPINS       = NUM_BANKS * 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe
);

    localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(HDR_BYTES);
    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(HDR_BYTES + 8);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(HDR_BYTES + 12);
    localparam logic [ADDR_W-1:0] A_HDR  = ADDR_W'(HDR_BYTES);

    // R1: reset state of the pins
    a_r1_reset_pins: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && pin_oe == '0));

    // R3: direction write drives the enables of bank 0
    a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DIR0) |=> (pin_oe[31:0] == ~$past(bus_wdata)));

    // R4: set port raises masked bits, keeps the rest
    a_r4_set_masked: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_SET0) |=>
            ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)) &&
            ((pin_out[31:0] & ~$past(bus_wdata)) == ($past(pin_out[31:0]) & ~$past(bus_wdata))));

    // R5: clear port lowers masked bits, keeps the rest
    a_r5_clr_masked: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CLR0) |=>
            ((pin_out[31:0] & $past(bus_wdata)) == '0) &&
            ((pin_out[31:0] & ~$past(bus_wdata)) == ($past(pin_out[31:0]) & ~$past(bus_wdata))));

    // R8: read data holds without a read strobe
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R9: header reads return zero
    a_r9_header_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr < A_HDR) |=> (bus_rdata == '0));

    // R9, R10: without a write no pin register moves
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_banked_regfile gpio_banked_regfile_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .ADDR_W      (ADDR_W),
    .HDR_BYTES   (HDR_BYTES),
    .STRIDE_BYTES(STRIDE_BYTES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/tb_gpio_banked_regfile.sv
module tb_gpio_banked_regfile;

    localparam int NB    = 5;
    localparam int NPINS = NB * 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] pin_out;
    logic [NPINS-1:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_banked_regfile dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  addr;
        logic [31:0] data;   // write data, or expected read value
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h14, 32'hA5A5_0000, 4'd6},   // R6 full replace
        '{1'b0, 8'h14, 32'hA5A5_0000, 4'd6},
        '{1'b1, 8'h18, 32'h0000_00FF, 4'd4},   // R4 set
        '{1'b0, 8'h18, 32'hA5A5_00FF, 4'd4},
        '{1'b1, 8'h1C, 32'hA000_000F, 4'd5},   // R5 clear
        '{1'b0, 8'h14, 32'h05A5_00F0, 4'd5},
        '{1'b0, 8'h1C, 32'h05A5_00F0, 4'd6},   // R6 clear port reads value
        '{1'b1, 8'h3C, 32'h1234_5678, 4'd11},  // R11 other bank
        '{1'b0, 8'h14, 32'h05A5_00F0, 4'd11},
        '{1'b0, 8'h3C, 32'h1234_5678, 4'd2},   // R2 bank 1 window
        '{1'b1, 8'h24, 32'hFFFF_FFFF, 4'd9},   // R9 reserved slot
        '{1'b0, 8'h24, 32'h0000_0000, 4'd9},
        '{1'b1, 8'hB4, 32'hDEAD_BEEF, 4'd2},   // R2 last bank
        '{1'b1, 8'hBC, 32'hFFFF_0000, 4'd5},
        '{1'b0, 8'hB4, 32'h0000_BEEF, 4'd5},
        '{1'b1, 8'h10, 32'h0000_FFFF, 4'd3},   // R3 direction
        '{1'b0, 8'h10, 32'h0000_FFFF, 4'd3},
        '{1'b0, 8'h04, 32'h0000_0000, 4'd9},   // header
        '{1'b0, 8'hD8, 32'h0000_0000, 4'd9},   // past last window
        '{1'b0, 8'h38, 32'hFFFF_FFFF, 4'd1},   // R1 untouched dir
        '{1'b1, 8'h40, 32'h8000_0000, 4'd4},
        '{1'b0, 8'h3C, 32'h9234_5678, 4'd4}
    };

    task automatic check(input string tag, input logic [NPINS-1:0] act,
                         input logic [NPINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0]      rv, r1, r3;
        logic [NPINS-1:0] snap_out, snap_oe;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 rdata", NPINS'(bus_rdata), '0);
        do_read(8'h10, rv);
        check("R1 dir reads all ones", NPINS'(rv), NPINS'(32'hFFFF_FFFF));

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) begin
                do_write(VECS[i].addr, VECS[i].data);
            end else begin
                do_read(VECS[i].addr, rv);
                check($sformatf("R%0d vec %0d", VECS[i].req, i),
                      NPINS'(rv), NPINS'(VECS[i].data));
            end
        end

        // R3 enables and driven values at the pins
        check("R3 oe bank0", NPINS'(pin_oe[31:0]), NPINS'(32'hFFFF_0000));
        check("R3 out bank0", NPINS'(pin_out[31:0]), NPINS'(32'h05A5_00F0));
        check("R2 out bank1 pins", NPINS'(pin_out[63:32]), NPINS'(32'h9234_5678));
        check("R2 out bank4 pins", NPINS'(pin_out[159:128]), NPINS'(32'h0000_BEEF));

        // R9 writes to reserved slot and header change nothing
        snap_out = pin_out; snap_oe = pin_oe;
        do_write(8'h28, 32'hFFFF_FFFF);
        do_write(8'h0C, 32'hFFFF_FFFF);
        check("R9 out after reserved writes", pin_out, snap_out);
        check("R9 oe after reserved writes", pin_oe, snap_oe);

        // R7/R10 input word on mixed input/output pins; writes to it ignored
        @(negedge clk);
        pin_in[31:0] = 32'h0F0F_0F0F;
        repeat (3) @(negedge clk);
        do_write(8'h20, 32'hFFFF_FFFF);
        do_read(8'h20, rv);
        check("R7 input level incl output pins", NPINS'(rv), NPINS'(32'h0F0F_0F0F));
        check("R10 input write ignored", pin_out, snap_out);

        // R7 synchronizer latency on bank 1
        @(negedge clk);
        pin_in[63:32] = 32'hC3C3_3C3C;
        bus_rd = 1'b1; bus_addr = 8'h48;
        @(negedge clk);
        r1 = bus_rdata;
        @(negedge clk);
        @(negedge clk);
        r3 = bus_rdata;
        bus_rd = 1'b0;
        check("R7 first edge old level", NPINS'(r1), '0);
        check("R7 third edge new level", NPINS'(r3), NPINS'(32'hC3C3_3C3C));

        // R8 rdata holds across a write
        do_write(8'h14, 32'h1111_2222);
        check("R8 rdata held", NPINS'(bus_rdata), NPINS'(32'hC3C3_3C3C));

        // R11 bank 0 write left bank 1 alone
        check("R11 bank1 pins", NPINS'(pin_out[63:32]), NPINS'(32'h9234_5678));

        finish_run();
    end

endmodule